// File: doc/BRIEF.md
# Handshaked Serial Command Framer

This block sits on the device side of a byte-wide command and response link. The host moves every byte through a shift register that both sides share. Two active-low lines in an 8-bit port-B value pace the transfer. The host pulls its request line low to offer a byte. The device answers by pulling its acknowledge line low, and releases it again once the host lets go of the request. The framer decodes this handshake. It gathers an opcode and its argument bytes into a command frame and hands the frame to an external executor. It then feeds the executor's response back to the host one byte at a time.

Each opcode has a command length and a response length, which the executor's table supplies combinationally for the byte on the shift register. A table entry of 0xFF means the length travels in the data stream instead. On the command side, the first byte after the opcode carries the argument count. On the response side, the device sends the response size as the first byte. The shift register and the execution of commands sit outside this block.

Top module: `cmd_framer`

## Requirements
- R1: After a synchronous reset the acknowledge output is high, and the byte-done pulse and frame-valid pulse are low.
- R2: A byte is accepted when the port-B value changes so that the request (bit 4) is low while the acknowledge (bit 3, as driven by the device) is high. On the next clock the acknowledge goes low and, if the byte is taken, a one-cycle byte-done pulse appears.
- R3: When the request is high while the acknowledge is low, the acknowledge returns high on the next clock and no byte is processed.
- R4: A port-B value equal to the last one seen is ignored. A change of other port-B bits while both handshake lines are low is also ignored: no pulse, and the acknowledge stays low.
- R5: In the idle state the accepted byte is the opcode. The low nibble selects the command length and the high nibble the response length in the bench's table. Once the count of argument bytes equals the command length, frame-valid pulses for one cycle together with the last byte's pulse, and it presents the opcode and the argument count. A zero command length dispatches on the opcode byte itself.
- R6: With a command length of 0xFF, the first byte after the opcode sets the argument count. A count of 0 dispatches at once.
- R7: Argument byte k can be read at index k with a latency of one clock. Bytes beyond the buffer depth still count toward completion but are not stored.
- R8: With a fixed response length N, the next N host-read bytes return the executor's byte at index 0, 1, ... on the byte output. After these N bytes the framer is idle. A zero-length response returns to idle as soon as the frame is dispatched.
- R9: With a response length of 0xFF, the first host-read byte returns the executor's response size, and that many data bytes follow.
- R10: A byte whose shift direction is wrong for the state (idle and command states need host-writing, which is direction 1; the response state needs host-reading, which is direction 0) still gets its acknowledge. It raises no pulse and changes no state.
- R11: A response position at or beyond the executor's response size sends 0x00 and still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| portb_i | input | 8 | Port-B value; bit 4 is the host request (active low) |
| dir_wr_i | input | 1 | Shift direction, 1 = host writing |
| sr_byte_i | input | 8 | Byte currently in the shift register |
| len_cmd_i | input | 8 | Command length for opcode sr_byte_i (0xFF = in-band) |
| len_rsp_i | input | 8 | Response length for opcode sr_byte_i (0xFF = in-band) |
| arg_idx_i | input | AW | Argument buffer read index |
| rsp_size_i | input | 8 | Response size from the executor, held after a frame |
| rsp_byte_i | input | 8 | Executor response byte at rsp_idx_o |
| ack_n_o | output | 1 | Device acknowledge (port-B bit 3), active low |
| irq_o | output | 1 | One-cycle byte-done pulse |
| tx_byte_o | output | 8 | Byte to load into the shift register for the host |
| frm_valid_o | output | 1 | One-cycle frame dispatch pulse |
| frm_op_o | output | 8 | Opcode of the dispatched frame |
| frm_cnt_o | output | 8 | Argument count of the dispatched frame |
| arg_byte_o | output | 8 | Argument byte read at arg_idx_i, one cycle later |
| rsp_idx_o | output | 8 | Index of the next response byte wanted |

## Verification
The bench sweeps every pairing of command lengths 0 to 5 with response lengths 0 to 4. A framer that is off by one in its completion compare would dispatch early or late, or would swallow the next opcode as an argument. Response positions past the executor's size check the zero padding. Separate runs cover an in-band command count of 0, an in-band count of 34 that overflows the 32-byte buffer, and the in-band response size. A design that stopped counting at the buffer depth would never dispatch. Wrong-direction bytes, repeated port values and changes of unrelated port bits are also driven. A decoder that reacted to levels rather than changes would accept phantom bytes.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RSP  = 2'd2
  } cf_state_t;

  localparam logic [7:0] LEN_INBAND = 8'hFF;
endpackage

// File: rtl/cf_handshake.sv
// Request/acknowledge decoder: reacts only to a change of the port value.
module cf_handshake #(
  parameter int REQ_BIT = 4,
  parameter int ACK_BIT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] portb_i,
  output logic       ack_n_o,
  output logic       byte_req_o
);
  localparam logic [7:0] IDLE_VAL = (8'h1 << REQ_BIT) | (8'h1 << ACK_BIT);

  logic [7:0] last_q;
  logic [7:0] seen;
  logic       chg;

  always_comb begin
    seen          = portb_i;
    seen[ACK_BIT] = ack_n_o;
  end

  assign chg        = (seen != last_q);
  assign byte_req_o = chg && !seen[REQ_BIT] && seen[ACK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_n_o <= 1'b1;
      last_q  <= IDLE_VAL;
    end else if (chg) begin
      last_q <= seen;
      if (seen[REQ_BIT] && !seen[ACK_BIT]) begin
        ack_n_o         <= 1'b1;
        last_q[ACK_BIT] <= 1'b1;
      end else if (byte_req_o) begin
        ack_n_o         <= 1'b0;
        last_q[ACK_BIT] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cf_argbuf.sv
// Argument store, synchronous read so it maps onto block RAM.
module cf_argbuf #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [7:0]    wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [7:0]    rd_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
    rd_o <= mem[ra_i];
  end
endmodule

// File: rtl/cf_sequencer.sv
// Framing state machine: opcode, lengths, argument count, response stream.
module cf_sequencer
  import cmd_framer_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_req_i,
  input  logic          dir_wr_i,
  input  logic [7:0]    sr_byte_i,
  input  logic [7:0]    len_cmd_i,
  input  logic [7:0]    len_rsp_i,
  input  logic [7:0]    rsp_size_i,
  input  logic [7:0]    rsp_byte_i,
  output logic          we_o,
  output logic [AW-1:0] wa_o,
  output logic          irq_o,
  output logic [7:0]    tx_byte_o,
  output logic          frm_valid_o,
  output logic [7:0]    frm_op_o,
  output logic [7:0]    frm_cnt_o,
  output logic [7:0]    rsp_idx_o,
  output cf_state_t     st_o
);
  localparam logic [8:0] DEPTH9 = 9'(DEPTH);

  cf_state_t  st_q, st_n;
  logic [7:0] op_q, op_n, clen_q, clen_n, rlen_q, rlen_n;
  logic [7:0] cc_q, cc_n, rc_q, rc_n, tx_q, tx_n;
  logic       cib_q, cib_n, rib_q, rib_n;
  logic       acc, disp;

  always_comb begin
    st_n = st_q;  op_n = op_q;  clen_n = clen_q;  rlen_n = rlen_q;
    cc_n = cc_q;  rc_n = rc_q;  tx_n = tx_q;
    cib_n = cib_q;  rib_n = rib_q;
    acc = 1'b0;  disp = 1'b0;  we_o = 1'b0;
    if (byte_req_i) begin
      unique case (st_q)
        ST_IDLE: if (dir_wr_i) begin
          acc    = 1'b1;
          op_n   = sr_byte_i;
          clen_n = len_cmd_i;
          cib_n  = (len_cmd_i == LEN_INBAND);
          rlen_n = len_rsp_i;
          rib_n  = (len_rsp_i == LEN_INBAND);
          cc_n   = 8'd0;
          rc_n   = 8'd0;
          st_n   = ST_CMD;
        end
        ST_CMD: if (dir_wr_i) begin
          acc = 1'b1;
          if (cib_q) begin
            clen_n = sr_byte_i;
            cib_n  = 1'b0;
          end else begin
            we_o = ({1'b0, cc_q} < DEPTH9);
            cc_n = cc_q + 8'd1;
          end
        end
        ST_RSP: if (!dir_wr_i) begin
          acc = 1'b1;
          if (rib_q) begin
            tx_n   = rsp_size_i;
            rlen_n = rsp_size_i;
            rib_n  = 1'b0;
          end else begin
            tx_n = (rc_q < rsp_size_i) ? rsp_byte_i : 8'h00;
            rc_n = rc_q + 8'd1;
          end
        end
        default: st_n = ST_IDLE;
      endcase
      if (st_n == ST_CMD && !cib_n && cc_n == clen_n) begin
        disp = 1'b1;
        st_n = ST_RSP;
      end
      if (st_n == ST_RSP && !rib_n && rc_n == rlen_n) st_n = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;  op_q <= '0;  clen_q <= '0;  rlen_q <= '0;
      cc_q <= '0;  rc_q <= '0;  tx_q <= '0;  cib_q <= 1'b0;  rib_q <= 1'b0;
      irq_o <= 1'b0;  frm_valid_o <= 1'b0;
    end else begin
      st_q <= st_n;  op_q <= op_n;  clen_q <= clen_n;  rlen_q <= rlen_n;
      cc_q <= cc_n;  rc_q <= rc_n;  tx_q <= tx_n;  cib_q <= cib_n;  rib_q <= rib_n;
      irq_o <= acc;  frm_valid_o <= disp;
    end
  end

  assign wa_o      = cc_q[AW-1:0];
  assign tx_byte_o = tx_q;
  assign frm_op_o  = op_q;
  assign frm_cnt_o = clen_q;
  assign rsp_idx_o = rc_q;
  assign st_o      = st_q;
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import cmd_framer_pkg::*;
#(
  parameter int REQ_BIT = 4,
  parameter int ACK_BIT = 3,
  parameter int DEPTH   = 32,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    portb_i,
  input  logic          dir_wr_i,
  input  logic [7:0]    sr_byte_i,
  input  logic [7:0]    len_cmd_i,
  input  logic [7:0]    len_rsp_i,
  input  logic [AW-1:0] arg_idx_i,
  input  logic [7:0]    rsp_size_i,
  input  logic [7:0]    rsp_byte_i,
  output logic          ack_n_o,
  output logic          irq_o,
  output logic [7:0]    tx_byte_o,
  output logic          frm_valid_o,
  output logic [7:0]    frm_op_o,
  output logic [7:0]    frm_cnt_o,
  output logic [7:0]    arg_byte_o,
  output logic [7:0]    rsp_idx_o
);
  logic          byte_req;
  logic          we;
  logic [AW-1:0] wa;
  cf_state_t     st;

  cf_handshake #(.REQ_BIT(REQ_BIT), .ACK_BIT(ACK_BIT)) u_hs (
    .clk(clk), .rst(rst), .portb_i(portb_i),
    .ack_n_o(ack_n_o), .byte_req_o(byte_req)
  );

  cf_sequencer #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .byte_req_i(byte_req), .dir_wr_i(dir_wr_i),
    .sr_byte_i(sr_byte_i), .len_cmd_i(len_cmd_i), .len_rsp_i(len_rsp_i),
    .rsp_size_i(rsp_size_i), .rsp_byte_i(rsp_byte_i),
    .we_o(we), .wa_o(wa), .irq_o(irq_o), .tx_byte_o(tx_byte_o),
    .frm_valid_o(frm_valid_o), .frm_op_o(frm_op_o), .frm_cnt_o(frm_cnt_o),
    .rsp_idx_o(rsp_idx_o), .st_o(st)
  );

  cf_argbuf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we_i(we), .wa_i(wa), .wd_i(sr_byte_i),
    .ra_i(arg_idx_i), .rd_o(arg_byte_o)
  );
endmodule

// File: rtl/cmd_framer_chk.sv
module cmd_framer_chk
  import cmd_framer_pkg::*;
#(
  parameter int REQ_BIT = 4
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] portb_i,
  input logic       dir_wr_i,
  input logic       ack_n_o,
  input logic       irq_o,
  input logic       frm_valid_o,
  input cf_state_t  st
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ack_n_o && !irq_o && !frm_valid_o));

  p_accept_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (!ack_n_o && $past(!portb_i[REQ_BIT])));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (!ack_n_o && portb_i[REQ_BIT]) |=> (ack_n_o && !irq_o));

  p_dir_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RSP && dir_wr_i) |=> !irq_o);

  p_dir_write_r10: assert property (@(posedge clk) disable iff (rst)
    (st != ST_RSP && !dir_wr_i) |=> !irq_o);

  p_frame_on_byte_r5: assert property (@(posedge clk) disable iff (rst)
    frm_valid_o |-> irq_o);
endmodule

bind cmd_framer cmd_framer_chk #(.REQ_BIT(REQ_BIT)) u_chk (
  .clk(clk), .rst(rst), .portb_i(portb_i), .dir_wr_i(dir_wr_i),
  .ack_n_o(ack_n_o), .irq_o(irq_o), .frm_valid_o(frm_valid_o), .st(st)
);

// File: tb/cmd_framer_tb_top.sv
`timescale 1ns/100ps
module cmd_framer_tb_top;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    portb_r = 8'h18;
  logic          dir_r = 1'b1;
  logic [7:0]    sr_r = 8'h00;
  logic [AW-1:0] aidx_r = '0;
  logic [7:0]    rsize_r = 8'd3;
  logic [7:0]    len_cmd, len_rsp, rsp_byte, rsp_idx;
  logic          ack_n, irq, frm_valid;
  logic [7:0]    tx_byte, frm_op, frm_cnt, arg_byte;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2.5 clk = ~clk;

  // Bench executor: length table and response data
  assign len_cmd  = (sr_r[3:0] == 4'hF) ? 8'hFF : {4'h0, sr_r[3:0]};
  assign len_rsp  = (sr_r[7:4] == 4'hF) ? 8'hFF : {4'h0, sr_r[7:4]};
  assign rsp_byte = 8'hA0 ^ rsp_idx;

  cmd_framer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .portb_i(portb_r), .dir_wr_i(dir_r),
    .sr_byte_i(sr_r), .len_cmd_i(len_cmd), .len_rsp_i(len_rsp),
    .arg_idx_i(aidx_r), .rsp_size_i(rsize_r), .rsp_byte_i(rsp_byte),
    .ack_n_o(ack_n), .irq_o(irq), .tx_byte_o(tx_byte),
    .frm_valid_o(frm_valid), .frm_op_o(frm_op), .frm_cnt_o(frm_cnt),
    .arg_byte_o(arg_byte), .rsp_idx_o(rsp_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input logic wr,
                      output logic g_irq, output logic g_frm, output logic [7:0] g_tx);
    @(negedge clk);
    sr_r = b; dir_r = wr; portb_r[4] = 1'b0;
    @(negedge clk);
    g_irq = irq; g_frm = frm_valid; g_tx = tx_byte;
    chk("R2 ack low after request", int'(ack_n), 0);
    portb_r[4] = 1'b1;
    @(negedge clk);
    chk("R3 ack released", int'(ack_n), 1);
    chk("R3 no pulse on release", int'(irq), 0);
  endtask

  task automatic rd_arg(input int k, input logic [7:0] exp);
    @(negedge clk); aidx_r = AW'(k);
    @(negedge clk); chk("R7 argument readback", int'(arg_byte), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic gi, gf;
    logic [7:0] gt, op;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack after reset", int'(ack_n), 1);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 frame after reset", int'(frm_valid), 0);

    // Sweep of command length x response length
    for (int cl = 0; cl <= 5; cl++) begin
      for (int rl = 0; rl <= 4; rl++) begin
        op = {4'(rl), 4'(cl)};
        xfer(op, 1'b1, gi, gf, gt);
        chk("R5 opcode accepted", int'(gi), 1);
        chk("R5 dispatch on opcode", int'(gf), int'(cl == 0));
        for (int k = 0; k < cl; k++) begin
          xfer(op ^ 8'(k * 7 + 1), 1'b1, gi, gf, gt);
          chk("R5 argument accepted", int'(gi), 1);
          chk("R5 dispatch on last argument", int'(gf), int'(k == cl - 1));
        end
        chk("R5 frame opcode", int'(frm_op), int'(op));
        chk("R5 frame count", int'(frm_cnt), cl);
        for (int k = 0; k < cl; k++) rd_arg(k, op ^ 8'(k * 7 + 1));
        for (int k = 0; k < rl; k++) begin
          xfer(8'h00, 1'b0, gi, gf, gt);
          chk("R8 response byte pulse", int'(gi), 1);
          chk("R11 response byte value", int'(gt), (k < 3) ? int'(8'hA0 ^ 8'(k)) : 0);
        end
      end
    end

    // Wrong direction in idle is ignored, then a proper opcode
    xfer(8'h55, 1'b0, gi, gf, gt);
    chk("R10 read in idle ignored", int'(gi), 0);
    xfer(8'h20, 1'b1, gi, gf, gt);
    chk("R10 later opcode framed", int'(gf), 1);
    chk("R10 opcode not replaced", int'(frm_op), 8'h20);
    xfer(8'h77, 1'b1, gi, gf, gt);
    chk("R10 write in response ignored", int'(gi), 0);
    chk("R10 tx unchanged", int'(gt), int'(tx_byte));
    xfer(8'h00, 1'b0, gi, gf, gt);
    chk("R10 response index intact", int'(gt), 8'hA0);
    xfer(8'h00, 1'b0, gi, gf, gt);
    chk("R8 second response byte", int'(gt), 8'hA1);

    // Unchanged value and unrelated bit changes are ignored
    @(negedge clk); sr_r = 8'h01; dir_r = 1'b1; portb_r[4] = 1'b0;
    @(negedge clk); chk("R2 opcode pulse", int'(irq), 1);
    repeat (3) begin
      @(negedge clk); chk("R4 held value no pulse", int'(irq), 0);
    end
    portb_r[0] = 1'b1;
    @(negedge clk); chk("R4 other bit no pulse", int'(irq), 0);
    chk("R4 ack stays low", int'(ack_n), 0);
    portb_r = 8'h18;
    @(negedge clk); chk("R3 ack released", int'(ack_n), 1);
    xfer(8'h9C, 1'b1, gi, gf, gt);
    chk("R4 one argument then frame", int'(gf), 1);
    chk("R4 frame count one", int'(frm_cnt), 1);
    rd_arg(0, 8'h9C);

    // In-band command length of zero
    xfer(8'h0F, 1'b1, gi, gf, gt);
    chk("R6 no dispatch on opcode", int'(gf), 0);
    xfer(8'h00, 1'b1, gi, gf, gt);
    chk("R6 zero count dispatches", int'(gf), 1);
    chk("R6 zero count", int'(frm_cnt), 0);

    // In-band count beyond buffer depth
    xfer(8'h0F, 1'b1, gi, gf, gt);
    xfer(8'd34, 1'b1, gi, gf, gt);
    chk("R6 count byte no dispatch", int'(gf), 0);
    for (int k = 0; k < 34; k++) begin
      xfer(8'h40 + 8'(k), 1'b1, gi, gf, gt);
      if (k >= 32 || k == 0) chk("R7 overflow byte counted", int'(gf), int'(k == 33));
    end
    chk("R7 overflow frame count", int'(frm_cnt), 34);
    rd_arg(0, 8'h40);
    rd_arg(31, 8'h5F);

    // In-band response size
    xfer(8'hF0, 1'b1, gi, gf, gt);
    chk("R9 frame on opcode", int'(gf), 1);
    xfer(8'h00, 1'b0, gi, gf, gt);
    chk("R9 size byte first", int'(gt), 3);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, 1'b0, gi, gf, gt);
      chk("R9 data after size", int'(gt), int'(8'hA0 ^ 8'(k)));
    end
    xfer(8'h00, 1'b1, gi, gf, gt);
    chk("R9 idle after response", int'(gf), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule